// File: doc/BRIEF.md
# Critical Temperature Alarm Controller

This block decides when an active-low, open-drain over-temperature line is pulled low. It watches three temperature channels (remote sensor 1, the on-die sensor and remote sensor 2), each with its own programmable critical limit. The measured value for a channel is refreshed by an external monitoring sequencer, once per monitoring cycle. That sequencer marks each refresh with a one-cycle update strobe for the channel.

At each update the block decides whether that channel is tripped. A channel trips when its reading is at least one LSB (0.25 °C) above its limit. It stays tripped until an update shows the reading at or below the limit. The alarm line is low whenever any channel is tripped. Each channel can be excluded with its own enable bit, and the whole function can be switched off with a global enable bit. A channel is also excluded when its limit is programmed to the bottom of the selected temperature encoding. Readings and limits are 10-bit codes with 2 fractional bits. They are read either as two's complement (−128 °C to +127.75 °C) or as offset-64 (code = temperature + 64 °C). Both are converted to one signed form before any comparison.

Top module: `thermal_trip_ctrl`

## Requirements
- R1: On the rising edge where a channel's update strobe is high, the channel trips if its reading is strictly greater than its limit. A reading exactly one code (0.25 °C) above the limit is enough. The `alarmN` output is low from that edge on.
- R2: A reading equal to its limit does not trip the channel at an update.
- R3: An update that shows a reading at or below its limit clears that channel's trip. `alarmN` returns high once no channel is tripped.
- R4: A channel's trip state changes only at that channel's update strobe. Changes to its reading or limit between strobes have no effect on `alarmN`, and neither do strobes of other channels.
- R5: `chanCfg` bit 5 enables remote 1 (channel 0, bus bits 9:0), bit 6 the local channel (channel 1, bits 19:10) and bit 7 remote 2 (channel 2, bits 29:20). An update of a disabled channel leaves it untripped, even if the channel was tripped before.
- R6: With `modeOffset` = 1, codes are read as offset-64: temperature in quarter-degrees is code − 256. A limit code of 0 (−64 °C) disables the channel's trip.
- R7: With `modeOffset` = 0, codes are two's complement. A limit code of 0x200 (−128 °C) disables the channel's trip. Comparison is signed: a reading of 0x004 (+1 °C) exceeds a limit of 0x3F8 (−2 °C).
- R8: When `ctrlCfg` bit 1 is 0, all trip states are cleared at the next rising edge and stay clear, so `alarmN` is high one cycle later. Strobes have no effect while the bit is 0.
- R9: While `rstN` is low, all trip states are cleared and `alarmN` is high.
- R10: `alarmN` is the NOR of the three trip states. Releasing one channel keeps the output low while another channel is still tripped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempBus | input | 30 | Three 10-bit readings, channel n in bits 10n+9:10n |
| limitBus | input | 30 | Three 10-bit critical limits, same layout as tempBus |
| updStrobe | input | 3 | One-cycle update strobe per channel, bit n for channel n |
| chanCfg | input | 8 | Per-channel enables in bits 5, 6, 7 |
| ctrlCfg | input | 8 | Global enable in bit 1 |
| modeOffset | input | 1 | 1 = offset-64 codes, 0 = two's complement codes |
| alarmN | output | 1 | Active-low over-temperature output (low = drive the pin low) |

## Verification
The bench drives a reading exactly equal to the limit and one exactly one code above it. A comparator built with `>=`, or one with an off-by-one, trips on the wrong side of that boundary. It changes readings with no strobe and strobes only the untripped channel. A design that compares continuously, or updates every channel on any strobe, then releases the output early. It uses codes that differ only in sign interpretation, and limits at the bottom code of each encoding. An unsigned compare, a swapped offset, or a floor check on the wrong encoding shows up as a wrong output level. It also clears one enable bit at a time and the global bit. A mis-indexed enable field, or a global disable that waits for a strobe, leaves the alarm in the wrong state.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int TRIP_CH = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic [TRIP_CH-1:0] capture;  // sample this channel's trip state
    logic [TRIP_CH-1:0] armed;    // channel allowed to trip
    logic               flush;    // clear all trip states
  } trip_cmd_t;
endpackage

// File: rtl/trip_code_conv.sv
module trip_code_conv #(
  parameter int CODE_W = 10,
  parameter int FRAC_W = 2
) (
  input  logic              [CODE_W-1:0] code,
  input  logic                           modeOffset,
  output logic signed       [CODE_W:0]   value
);
  localparam int SW       = CODE_W + 1;
  localparam int OFFSET_Q = 64 << FRAC_W;

  always_comb begin
    if (modeOffset) value = $signed({1'b0, code}) - $signed(SW'(OFFSET_Q));
    else            value = $signed({code[CODE_W-1], code});
  end
endmodule

// File: rtl/trip_control.sv
module trip_control
  import trip_pkg::*;
#(
  parameter int EN_LSB     = 5,
  parameter int GLOBAL_BIT = 1
) (
  input  logic [TRIP_CH-1:0] updStrobe,
  input  logic [7:0]         chanCfg,
  input  logic [7:0]         ctrlCfg,
  output trip_cmd_t          cmd
);
  logic globalOn;
  logic unusedCfgBits;

  assign globalOn      = ctrlCfg[GLOBAL_BIT];
  assign unusedCfgBits = ^{chanCfg, ctrlCfg};

  always_comb begin
    cmd.flush   = ~globalOn;
    cmd.capture = updStrobe & {TRIP_CH{globalOn}};
    cmd.armed   = chanCfg[EN_LSB +: TRIP_CH] & {TRIP_CH{globalOn}};
  end
endmodule

// File: rtl/trip_datapath.sv
module trip_datapath
  import trip_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int FRAC_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [TRIP_CH*CODE_W-1:0]  tempBus,
  input  logic [TRIP_CH*CODE_W-1:0]  limitBus,
  input  logic                       modeOffset,
  input  trip_cmd_t                  cmd,
  output logic                       alarmN
);
  localparam int SW       = CODE_W + 1;
  localparam int OFFSET_Q = 64 << FRAC_W;
  localparam int HALF_Q   = 1 << (CODE_W - 1);
  localparam logic signed [SW-1:0] FLOOR_OFF = SW'(-OFFSET_Q);
  localparam logic signed [SW-1:0] FLOOR_TWO = SW'(-HALF_Q);

  logic signed [SW-1:0] floorVal;
  logic [TRIP_CH-1:0]   overLimit;
  logic [TRIP_CH-1:0]   floorHit;
  logic [TRIP_CH-1:0]   tripState;

  assign floorVal = modeOffset ? FLOOR_OFF : FLOOR_TWO;

  for (genvar g = 0; g < TRIP_CH; g++) begin : g_chan
    logic signed [SW-1:0] tempVal;
    logic signed [SW-1:0] limitVal;

    trip_code_conv #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_tempConv (
      .code      (tempBus[g*CODE_W +: CODE_W]),
      .modeOffset(modeOffset),
      .value     (tempVal)
    );
    trip_code_conv #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_limitConv (
      .code      (limitBus[g*CODE_W +: CODE_W]),
      .modeOffset(modeOffset),
      .value     (limitVal)
    );

    assign overLimit[g] = tempVal > limitVal;
    assign floorHit[g]  = limitVal <= floorVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripState <= '0;
    end else if (cmd.flush) begin
      tripState <= '0;
    end else begin
      for (int i = 0; i < TRIP_CH; i++) begin
        if (cmd.capture[i])
          tripState[i] <= cmd.armed[i] & overLimit[i] & ~floorHit[i];
      end
    end
  end

  assign alarmN = ~|tripState;
endmodule

// File: rtl/thermal_trip_ctrl.sv
module thermal_trip_ctrl
  import trip_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int FRAC_W     = 2,
  parameter int EN_LSB     = 5,
  parameter int GLOBAL_BIT = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TRIP_CH*CODE_W-1:0] tempBus,
  input  logic [TRIP_CH*CODE_W-1:0] limitBus,
  input  logic [TRIP_CH-1:0]        updStrobe,
  input  logic [7:0]                chanCfg,
  input  logic [7:0]                ctrlCfg,
  input  logic                      modeOffset,
  output logic                      alarmN
);
  trip_cmd_t cmd;

  trip_control #(.EN_LSB(EN_LSB), .GLOBAL_BIT(GLOBAL_BIT)) u_control (
    .updStrobe(updStrobe),
    .chanCfg  (chanCfg),
    .ctrlCfg  (ctrlCfg),
    .cmd      (cmd)
  );

  trip_datapath #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .tempBus   (tempBus),
    .limitBus  (limitBus),
    .modeOffset(modeOffset),
    .cmd       (cmd),
    .alarmN    (alarmN)
  );
endmodule

// File: rtl/thermal_trip_checker.sv
module thermal_trip_checker (
  input logic        clk,
  input logic        rstN,
  input logic [29:0] tempBus,
  input logic [29:0] limitBus,
  input logic [2:0]  updStrobe,
  input logic [7:0]  chanCfg,
  input logic [7:0]  ctrlCfg,
  input logic        modeOffset,
  input logic        alarmN
);
  logic unusedChk;
  assign unusedChk = ^{chanCfg[4:0], ctrlCfg[7:2], ctrlCfg[0]};

  function automatic logic signed [10:0] toQuarter(input logic [9:0] c, input logic offs);
    if (offs) return $signed({1'b0, c}) - 11'sd256;
    return $signed({c[9], c});
  endfunction

  logic [2:0] hot;
  logic [2:0] atFloor;
  always_comb begin
    for (int i = 0; i < 3; i++) begin
      hot[i]     = toQuarter(tempBus[i*10 +: 10], modeOffset) >
                   toQuarter(limitBus[i*10 +: 10], modeOffset);
      atFloor[i] = modeOffset ? (limitBus[i*10 +: 10] == 10'h000)
                              : (limitBus[i*10 +: 10] == 10'h200);
    end
  end

  // R9: output released during reset
  always @(posedge clk) begin
    if (!rstN) p_reset_idle_r9: assert (alarmN);
  end

  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R1, R5, R6, R7: armed channel above its limit pulls the output low
    p_trip_low_r1: assert property (@(posedge clk) disable iff (!rstN)
      (updStrobe[g] && ctrlCfg[1] && chanCfg[5+g] && hot[g] && !atFloor[g]) |=> !alarmN);
  end

  // R3: all channels updated and none above limit releases the output
  p_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe == 3'b111 && hot == 3'b000) |=> alarmN);

  // R4: no strobe, global on -> output does not move
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe == 3'b000 && ctrlCfg[1]) |=> $stable(alarmN));

  // R8: global off releases the output on the next edge
  p_global_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlCfg[1] |=> alarmN);
endmodule

bind thermal_trip_ctrl thermal_trip_checker u_tripChecker (
  .clk       (clk),
  .rstN      (rstN),
  .tempBus   (tempBus),
  .limitBus  (limitBus),
  .updStrobe (updStrobe),
  .chanCfg   (chanCfg),
  .ctrlCfg   (ctrlCfg),
  .modeOffset(modeOffset),
  .alarmN    (alarmN)
);

// File: tb/thermal_trip_ctrl_bench.sv
`timescale 1ns/1ps
module thermal_trip_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [29:0] tempBus;
  logic [29:0] limitBus;
  logic [2:0]  updStrobe;
  logic [7:0]  chanCfg;
  logic [7:0]  ctrlCfg;
  logic        modeOffset;
  logic        alarmN;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  thermal_trip_ctrl u_thermal_trip_ctrl (
    .clk(clk), .rstN(rstN), .tempBus(tempBus), .limitBus(limitBus),
    .updStrobe(updStrobe), .chanCfg(chanCfg), .ctrlCfg(ctrlCfg),
    .modeOffset(modeOffset), .alarmN(alarmN)
  );

  task automatic chk(input string req, input logic exp);
    nChecks++;
    if (alarmN !== exp) begin
      nErrors++;
      $display("FAIL %s: alarmN=%0b expected %0b", req, alarmN, exp);
    end
  endtask

  task automatic setChan(input int ch, input logic [9:0] t, input logic [9:0] l);
    tempBus[ch*10 +: 10]  = t;
    limitBus[ch*10 +: 10] = l;
  endtask

  // pulse strobes for one cycle; returns at the negedge after the capture edge
  task automatic pulse(input logic [2:0] mask);
    @(negedge clk) updStrobe = mask;
    @(negedge clk) updStrobe = 3'b000;
  endtask

  task automatic t_reset();
    chk("R9 reset idle", 1'b1);
  endtask

  task automatic t_boundary();
    setChan(0, 10'd100, 10'd100);
    pulse(3'b001);
    chk("R2 equal no trip", 1'b1);
    setChan(0, 10'd101, 10'd100);
    pulse(3'b001);
    chk("R1 one LSB over trips", 1'b0);
  endtask

  task automatic t_hold();
    setChan(0, 10'd50, 10'd100);
    repeat (5) @(negedge clk);
    chk("R4 no strobe holds", 1'b0);
    setChan(1, 10'd10, 10'd100);
    pulse(3'b010);
    chk("R4 other strobe holds", 1'b0);
    setChan(0, 10'd100, 10'd100);
    pulse(3'b001);
    chk("R3 equal releases", 1'b1);
  endtask

  task automatic t_or();
    setChan(0, 10'd200, 10'd100);
    setChan(2, 10'd200, 10'd100);
    pulse(3'b101);
    chk("R10 two tripped", 1'b0);
    setChan(0, 10'd20, 10'd100);
    pulse(3'b001);
    chk("R10 one still tripped", 1'b0);
    setChan(2, 10'd20, 10'd100);
    pulse(3'b100);
    chk("R3 last release", 1'b1);
  endtask

  task automatic t_enable();
    @(negedge clk) chanCfg = 8'hC0;
    setChan(0, 10'd200, 10'd100);
    pulse(3'b001);
    chk("R5 remote1 disabled bit5", 1'b1);
    @(negedge clk) chanCfg = 8'h40;
    setChan(0, 10'd20, 10'd100);
    setChan(1, 10'd200, 10'd100);
    pulse(3'b010);
    chk("R5 local enabled bit6", 1'b0);
    @(negedge clk) chanCfg = 8'h00;
    pulse(3'b010);
    chk("R5 disabled update clears", 1'b1);
    @(negedge clk) chanCfg = 8'h80;
    setChan(1, 10'd20, 10'd100);
    setChan(2, 10'd200, 10'd100);
    pulse(3'b100);
    chk("R5 remote2 enabled bit7", 1'b0);
    setChan(2, 10'd20, 10'd100);
    pulse(3'b100);
    chk("R5 remote2 release", 1'b1);
    @(negedge clk) chanCfg = 8'hE0;
  endtask

  task automatic t_offset();
    @(negedge clk) modeOffset = 1'b1;
    setChan(2, 10'd300, 10'd0);
    pulse(3'b100);
    chk("R6 offset floor disables", 1'b1);
    setChan(2, 10'd300, 10'd1);
    pulse(3'b100);
    chk("R6 offset above floor trips", 1'b0);
    setChan(2, 10'd1, 10'd1);
    pulse(3'b100);
    chk("R6 offset equal releases", 1'b1);
    // 0x004 vs 0x3F8 in offset mode: -63 C vs +190 C, no trip
    setChan(2, 10'h004, 10'h3F8);
    pulse(3'b100);
    chk("R6 offset reads codes unsigned", 1'b1);
  endtask

  task automatic t_twos();
    @(negedge clk) modeOffset = 1'b0;
    setChan(1, 10'h100, 10'h200);
    pulse(3'b010);
    chk("R7 twos floor disables", 1'b1);
    setChan(1, 10'h004, 10'h3F8);
    pulse(3'b010);
    chk("R7 signed compare trips", 1'b0);
    setChan(1, 10'h3F8, 10'h3F8);
    pulse(3'b010);
    chk("R7 negative equal releases", 1'b1);
  endtask

  task automatic t_global();
    setChan(0, 10'd200, 10'd100);
    pulse(3'b001);
    chk("R8 tripped before disable", 1'b0);
    @(negedge clk) ctrlCfg = 8'h00;
    @(negedge clk);
    chk("R8 global off releases", 1'b1);
    pulse(3'b001);
    chk("R8 strobe ignored while off", 1'b1);
    @(negedge clk) ctrlCfg = 8'h02;
    @(negedge clk);
    chk("R8 re-enable waits for strobe", 1'b1);
    pulse(3'b001);
    chk("R8 trips after re-enable", 1'b0);
    setChan(0, 10'd20, 10'd100);
    pulse(3'b001);
    chk("R3 final release", 1'b1);
  endtask

  initial begin
    rstN = 1'b0; tempBus = '0; limitBus = '0; updStrobe = 3'b000;
    chanCfg = 8'hE0; ctrlCfg = 8'h02; modeOffset = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_boundary();
    t_hold();
    t_or();
    t_enable();
    t_offset();
    t_twos();
    t_global();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule